// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

The block turns IEEE single-precision values into 32-bit integers, either two's-complement signed or unsigned, under a per-operation power-of-two scale. The scale is an unsigned 5-bit count. It is added to the input's unbiased exponent before conversion, so an input x yields trunc(x * 2^scale).

Fractions are discarded toward zero. Results outside the target range clamp to the nearest representable bound. A sticky saturation flag remembers that any clamp occurred since it was last cleared.

The datapath carries a parameterised number of 32-bit lanes (four by default, 128 bits in all). Each lane converts on its own under a shared scale and mode. The result is registered, so a strobe on the input valid appears one cycle later on the output valid with the converted word. Software or a controller samples the flag and clears it with a synchronous clear input.

Top module: `f2i_sat`

## Requirements
- R1: During and straight after reset, `valid_o`, `data_o` and `sat_o` are all zero.
- R2: `valid_o` equals `valid_i` from the previous cycle. `data_o` changes only in the cycle after `valid_i` is high, and otherwise holds its value.
- R3: A NaN lane (bits 30:23 all ones, bits 22:0 nonzero, either sign) converts to 0 in both modes and raises no saturation.
- R4: Let e = bits 30:23 minus 127 plus `scale_i`. If e < 0, the lane converts to 0 with no saturation in both modes, whatever the sign.
- R5: In signed mode (`signed_i`=1) with 0 <= e <= 30, the lane gives the magnitude truncated toward zero. This is ({1, bits 22:0} << 7) >> (30 - e), two's-complement negated when bit 31 is set.
- R6: In signed mode with e >= 31 (including infinities), a positive lane gives 0x7FFFFFFF and a negative lane gives 0x80000000, and saturation is raised.
- R7: In signed mode, a lane whose 32-bit sum input + (`scale_i` << 23) is exactly 0xCF000000 (the value -2^31) gives 0x80000000 and raises no saturation.
- R8: In unsigned mode (`signed_i`=0), a non-NaN lane with bit 31 set and e >= 0 gives 0 and raises saturation.
- R9: In unsigned mode, a positive lane with e >= 32 (including +infinity) gives 0xFFFFFFFF and raises saturation.
- R10: In unsigned mode with a positive lane and 0 <= e <= 31, the result is ({1, bits 22:0} << 8) >> (31 - e).
- R11: `sat_o` is sticky. It rises in the cycle after an accepted conversion in which any lane saturated. It then stays high until cleared. A saturation in the same cycle as `clr_i` leaves it high.
- R12: With `clr_i` high and no saturating conversion in that cycle, `sat_o` is low in the next cycle.
- R13: Lanes convert independently. Lane k occupies bits 32k+31:32k of `data_i` and `data_o`, and a saturation in any lane raises the shared flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands valid |
| signed_i | input | 1 | 1: signed target, 0: unsigned target |
| scale_i | input | 5 | Power-of-two scale added to exponent |
| data_i | input | 32*LANES | Packed single-precision lanes |
| clr_i | input | 1 | Synchronous clear of saturation flag |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| data_o | output | 32*LANES | Packed integer results |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bound checker watches several properties on every cycle: the one-cycle valid alignment, that the result holds while idle, flag stickiness and clearing, and the lane-0 zero results for NaN and negative effective exponents. It also checks that negative unsigned inputs are flagged. The exact integer values of in-range truncation, the choice of clamp bound, the -2^31 flag exemption and the lane independence can only be shown by the bench's vector table and directed scenarios, whose expected words were worked out by hand from the requirements.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int WORD_W   = 32;
  localparam int SCALE_W  = 5;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int EXP_BIAS = 127;
  localparam int EFF_W    = EXP_W + 2;
  localparam logic [WORD_W-1:0] S_MAX   = 32'h7FFF_FFFF;
  localparam logic [WORD_W-1:0] S_MIN   = 32'h8000_0000;
  localparam logic [WORD_W-1:0] U_MAX   = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] NEG_2_31 = 32'hCF00_0000;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } sp_t;
endpackage

// File: rtl/f2i_lane.sv
module f2i_lane
  import f2i_pkg::*;
(
  input  logic [WORD_W-1:0]  x_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               signed_i,
  output logic [WORD_W-1:0]  y_o,
  output logic               sat_o
);
  sp_t                     x;
  logic                    is_nan;
  logic signed [EFF_W-1:0] eff;
  logic [FRAC_W:0]         sig;
  logic [4:0]              sh_s, sh_u;
  logic [WORD_W-1:0]       mag_s, mag_u, scaled;
  logic                    exact_min;

  assign x      = sp_t'(x_i);
  assign is_nan = (&x.exp) && (|x.frac);
  assign eff    = $signed({2'b00, x.exp}) - EFF_W'(EXP_BIAS)
                + $signed({{(EFF_W-SCALE_W){1'b0}}, scale_i});
  assign sig    = {1'b1, x.frac};
  assign sh_s   = 5'd30 - eff[4:0];
  assign sh_u   = 5'd31 - eff[4:0];
  assign mag_s  = {1'b0, sig, 7'b0} >> sh_s;
  assign mag_u  = {sig, 8'b0} >> sh_u;
  // exponent-field addition of the scale; exempts exact -2^31
  assign scaled    = x_i + {{(WORD_W-SCALE_W-FRAC_W){1'b0}}, scale_i, {FRAC_W{1'b0}}};
  assign exact_min = (scaled == NEG_2_31);

  always_comb begin
    y_o   = '0;
    sat_o = 1'b0;
    if (is_nan || eff < 0) begin
      y_o = '0;
    end else if (signed_i) begin
      if (eff >= EFF_W'(31)) begin
        y_o   = x.sgn ? S_MIN : S_MAX;
        sat_o = !exact_min;
      end else begin
        y_o = x.sgn ? (~mag_s) + 32'd1 : mag_s;
      end
    end else begin
      if (x.sgn) begin
        y_o   = '0;
        sat_o = 1'b1;
      end else if (eff >= EFF_W'(32)) begin
        y_o   = U_MAX;
        sat_o = 1'b1;
      end else begin
        y_o = mag_u;
      end
    end
  end
endmodule

// File: rtl/f2i_sticky.sv
module f2i_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic flag_o
);
  // set wins over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/f2i_sat.sv
module f2i_sat
  import f2i_pkg::*;
#(
  parameter int LANES = 4,
  localparam int BUS_W = LANES * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               signed_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [BUS_W-1:0]   data_i,
  input  logic               clr_i,
  output logic               valid_o,
  output logic [BUS_W-1:0]   data_o,
  output logic               sat_o
);
  logic [BUS_W-1:0] conv;
  logic [LANES-1:0] lane_sat;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    f2i_lane u_lane (
      .x_i      (data_i[k*WORD_W +: WORD_W]),
      .scale_i  (scale_i),
      .signed_i (signed_i),
      .y_o      (conv[k*WORD_W +: WORD_W]),
      .sat_o    (lane_sat[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= conv;
    end
  end

  f2i_sticky u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .set_i  (valid_i & (|lane_sat)),
    .flag_o (sat_o)
  );
endmodule

// File: rtl/f2i_sat_chk.sv
module f2i_sat_chk
  import f2i_pkg::*;
#(
  parameter int LANES = 4,
  localparam int BUS_W = LANES * WORD_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               signed_i,
  input logic [SCALE_W-1:0] scale_i,
  input logic [BUS_W-1:0]   data_i,
  input logic               clr_i,
  input logic               valid_o,
  input logic [BUS_W-1:0]   data_o,
  input logic               sat_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic       l0_nan, l0_sgn;
  logic [9:0] l0_biased;
  assign l0_nan    = (&data_i[30:23]) && (|data_i[22:0]);
  assign l0_sgn    = data_i[31];
  assign l0_biased = {2'b0, data_i[30:23]} + {5'b0, scale_i};

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(valid_i) |-> $stable(data_o));
  p_nan_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && l0_nan |=> data_o[31:0] == '0);
  p_neg_exp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !l0_nan && l0_biased < 10'd127 |=> data_o[31:0] == '0);
  p_uns_neg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !signed_i && l0_sgn && !l0_nan && l0_biased >= 10'd127
    |=> sat_o && data_o[31:0] == '0);
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o && !clr_i |=> sat_o);
  p_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !valid_i |=> !sat_o);
  p_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $rose(sat_o) |-> $past(valid_i));
endmodule

bind f2i_sat f2i_sat_chk #(.LANES(LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .signed_i (signed_i),
  .scale_i  (scale_i),
  .data_i   (data_i),
  .clr_i    (clr_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .sat_o    (sat_o)
);

// File: tb/sim_f2i_sat.sv
module sim_f2i_sat;
  localparam int LANES = 4;
  localparam int BUS_W = LANES * 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic             signed_i = 1'b0;
  logic [4:0]       scale_i = '0;
  logic [BUS_W-1:0] data_i = '0;
  logic             clr_i = 1'b0;
  logic             valid_o;
  logic [BUS_W-1:0] data_o;
  logic             sat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  f2i_sat #(.LANES(LANES)) u0 (
    .clk_i, .rst_ni, .valid_i, .signed_i, .scale_i, .data_i, .clr_i,
    .valid_o, .data_o, .sat_o
  );

  // {signed, scale, input, expected, sat}
  localparam int NV = 23;
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 5'd0,  32'h3F80_0000, 32'h0000_0001, 1'b0},  // R5 1.0
    {1'b1, 5'd0,  32'hBFC0_0000, 32'hFFFF_FFFF, 1'b0},  // R5 -1.5
    {1'b1, 5'd4,  32'h4030_0000, 32'h0000_002C, 1'b0},  // R5 2.75*16
    {1'b1, 5'd0,  32'h3F40_0000, 32'h0000_0000, 1'b0},  // R4 0.75
    {1'b1, 5'd0,  32'h7FC0_0000, 32'h0000_0000, 1'b0},  // R3 NaN
    {1'b1, 5'd0,  32'h4F00_0000, 32'h7FFF_FFFF, 1'b1},  // R6 2^31
    {1'b1, 5'd0,  32'hCF00_0000, 32'h8000_0000, 1'b0},  // R7 -2^31
    {1'b1, 5'd1,  32'hCE80_0000, 32'h8000_0000, 1'b0},  // R7 -2^30*2
    {1'b1, 5'd0,  32'hCF80_0000, 32'h8000_0000, 1'b1},  // R6 -2^32
    {1'b1, 5'd0,  32'h7F80_0000, 32'h7FFF_FFFF, 1'b1},  // R6 +Inf
    {1'b0, 5'd0,  32'h4070_0000, 32'h0000_0003, 1'b0},  // R10 3.75
    {1'b0, 5'd0,  32'hBF80_0000, 32'h0000_0000, 1'b1},  // R8 -1.0
    {1'b0, 5'd0,  32'hBF00_0000, 32'h0000_0000, 1'b0},  // R4 -0.5
    {1'b0, 5'd0,  32'h4F80_0000, 32'hFFFF_FFFF, 1'b1},  // R9 2^32
    {1'b0, 5'd0,  32'h4F00_0000, 32'h8000_0000, 1'b0},  // R10 2^31
    {1'b0, 5'd31, 32'h3F80_0000, 32'h8000_0000, 1'b0},  // R10 1*2^31
    {1'b0, 5'd31, 32'h4000_0000, 32'hFFFF_FFFF, 1'b1},  // R9 2*2^31
    {1'b1, 5'd31, 32'h3F80_0000, 32'h7FFF_FFFF, 1'b1},  // R6 1*2^31
    {1'b1, 5'd0,  32'h4EFF_FFFF, 32'h7FFF_FF80, 1'b0},  // R5 largest
    {1'b0, 5'd0,  32'hFFC0_0001, 32'h0000_0000, 1'b0},  // R3 -NaN
    {1'b1, 5'd0,  32'h8000_0000, 32'h0000_0000, 1'b0},  // R4 -0
    {1'b1, 5'd0,  32'hC2C9_0000, 32'hFFFF_FF9C, 1'b0},  // R5 -100.5
    {1'b0, 5'd3,  32'h3FC0_0000, 32'h0000_000C, 1'b0}   // R10 1.5*8
  };

  task automatic check(input string req, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(input logic sg, input logic [4:0] sc,
                       input logic [BUS_W-1:0] d, input logic clr);
    @(negedge clk_i);
    valid_i = 1'b1; signed_i = sg; scale_i = sc; data_i = d; clr_i = clr;
    @(negedge clk_i);
    valid_i = 1'b0; clr_i = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] held;
    repeat (3) @(negedge clk_i);
    check("R1 valid", BUS_W'(valid_o), '0);
    check("R1 data", data_o, '0);
    check("R1 sat", BUS_W'(sat_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {data_o[BUS_W-3:0], valid_o, sat_o}, '0);

    // table walk: clear with each vector so flag reflects that vector only
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][70], VEC[i][69:65], {96'b0, VEC[i][64:33]}, 1'b1);
      check($sformatf("R3-R10 vec%0d data", i), data_o, {96'b0, VEC[i][32:1]});
      check($sformatf("vec%0d sat", i), BUS_W'(sat_o), BUS_W'(VEC[i][0]));
      check("R2 valid_o", BUS_W'(valid_o), BUS_W'(1'b1));
    end

    // R11: sticky across a clean conversion and idle
    apply(1'b1, 5'd0, {96'b0, 32'h4F00_0000}, 1'b1);
    check("R11 set with clr", BUS_W'(sat_o), BUS_W'(1'b1));
    apply(1'b1, 5'd0, {96'b0, 32'h3F80_0000}, 1'b0);
    check("R11 held sat", BUS_W'(sat_o), BUS_W'(1'b1));
    check("R11 data", data_o, {96'b0, 32'h1});
    @(negedge clk_i);
    check("R11 held idle", BUS_W'(sat_o), BUS_W'(1'b1));
    check("R2 valid low", BUS_W'(valid_o), '0);

    // R2: data holds with valid low while inputs move
    held = data_o;
    data_i = {4{32'h4B00_0000}};
    repeat (2) @(negedge clk_i);
    check("R2 hold", data_o, held);

    // R12: clear alone
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    check("R12 cleared", BUS_W'(sat_o), '0);
    check("R12 data unchanged", data_o, held);

    // R13: lanes independent, OR of saturations
    apply(1'b1, 5'd0, {32'h4F80_0000, 32'h4030_0000, 32'hBFC0_0000, 32'h3F80_0000}, 1'b1);
    check("R13 lanes signed", data_o,
          {32'h7FFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFF, 32'h0000_0001});
    check("R13 sat from lane3", BUS_W'(sat_o), BUS_W'(1'b1));
    apply(1'b0, 5'd2, {4{32'h3F80_0000}}, 1'b1);
    check("R13 lanes unsigned", data_o, {4{32'h0000_0004}});
    check("R13 no sat", BUS_W'(sat_o), '0);
    apply(1'b0, 5'd0, {32'h3F80_0000, 32'hBF80_0000, 32'h3F80_0000, 32'h3F80_0000}, 1'b0);
    check("R13 lane2 neg", data_o, {32'h1, 32'h0, 32'h1, 32'h1});
    check("R13 sat from lane2", BUS_W'(sat_o), BUS_W'(1'b1));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule